// File: doc/BRIEF.md
# EDID Base Block Timing Parser

This block takes the 128-byte base block of a display identification record as a byte stream and produces the preferred video timing that the record carries. Each byte arrives with a valid strobe. The final byte carries a last strobe. While the bytes pass, the block checks the 8-byte signature and keeps a running modulo-256 sum. It also keeps the first in-use 18-byte detailed timing descriptor of the four held in the block.

When the last byte is accepted, the block raises `done` and reports an error code. On success it also reports the decoded pixel clock, active and blanking sizes, sync offsets, sync widths and sync polarities. A display controller reads these results to program its timing generator. The results stay fixed until the first byte of the next block arrives.

Top module: `edid_timing_parser`

## Requirements
- R1: Bytes 0 to 7 of the block must read 00, FF, FF, FF, FF, FF, FF, 00. Any other value reports `err_code` = 1 (bad header).
- R2: The 8-bit sum of all 128 bytes must be zero. Any other sum reports `err_code` = 2 (bad checksum).
- R3: Four descriptors of 18 bytes each start at byte 54. A descriptor whose bytes 0 and 1 are both zero is skipped. The lowest-numbered descriptor with either byte nonzero is the one decoded, and later descriptors have no effect.
- R4: If all four descriptors are skipped, `err_code` = 3 (no timing).
- R5: `pclk_khz` equals the little-endian 16-bit value in descriptor bytes 0 (low) and 1 (high), multiplied by 10.
- R6: Horizontal active is {byte4[7:4], byte2}. Horizontal blanking is {byte4[3:0], byte3}. Vertical active is {byte7[7:4], byte5}. Vertical blanking is {byte7[3:0], byte6}.
- R7: Byte 11 holds the high bits of the sync fields:
  - horizontal sync offset = {byte11[7:6], byte8}
  - horizontal sync width = {byte11[5:4], byte9}
  - vertical sync offset = {byte11[3:2], byte10[7:4]}
  - vertical sync width = {byte11[1:0], byte10[3:0]}
- R8: When byte17[4:3] = 2'b11, `vsync_pos` = byte17[2] and `hsync_pos` = byte17[1]. A value of 1 means positive. For any other byte17[4:3], both outputs are 0.
- R9: When several faults apply, the reported code follows the order bad header, then bad checksum, then no timing.
- R10: A block is malformed, and reports code 1, if last comes on any byte other than the 128th, or if more than 128 bytes arrive before last.
- R11: `done` rises in the cycle after the byte carrying last is accepted. While no byte is accepted, `done` and all results stay unchanged. The first byte of the next block clears `done` in the following cycle.
- R12: When `err_code` is not 0, all timing outputs are zero.
- R13: After reset, `done` is 0 and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Block byte |
| in_last | input | 1 | Marks the final byte of a block |
| done | output | 1 | Results valid |
| err_code | output | 2 | 0 ok, 1 bad header, 2 bad checksum, 3 no timing |
| pclk_khz | output | 20 | Pixel clock in kHz |
| h_active | output | 12 | Horizontal active pixels |
| h_blank | output | 12 | Horizontal blanking pixels |
| v_active | output | 12 | Vertical active lines |
| v_blank | output | 12 | Vertical blanking lines |
| h_sync_off | output | 10 | Horizontal sync offset |
| h_sync_wid | output | 10 | Horizontal sync width |
| v_sync_off | output | 6 | Vertical sync offset |
| v_sync_wid | output | 6 | Vertical sync width |
| hsync_pos | output | 1 | Horizontal sync positive |
| vsync_pos | output | 1 | Vertical sync positive |

## Verification
The bench places the in-use descriptor in each of the four slots, with junk in the skipped slots and a decoy timing in the later ones. A design that did not stop capturing at the first in-use slot would report the decoy. A design that tested only byte 0 for "in use" would skip a descriptor whose pixel clock has only its high byte set. Field values reach their top split bits, so a design that places the byte-11 or nibble extensions wrongly shows wrong high bits. The bench also covers:
- short and overlong blocks, and blocks with two faults at once, which expose a wrong length check or a wrong error priority;
- the non-separate sync case, which exposes polarity bits passed through without the sync-type test;
- idle gaps inside a block, which expose a counter that advances without a valid byte;
- the hold of results after `done` and the drop of `done` when the next block starts.

// File: rtl/edid_pkg.sv
// Shared types and constants for the EDID timing parser.
// Assumes the block signature is 8 bytes long with zero bytes at both ends.
package edid_pkg;

    localparam int SIG_LEN = 8;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_HEADER    = 2'd1,
        ERR_CHECKSUM  = 2'd2,
        ERR_NO_TIMING = 2'd3
    } edid_err_e;

    typedef struct packed {
        logic [19:0] pclk_khz;
        logic [11:0] h_act;
        logic [11:0] h_blk;
        logic [11:0] v_act;
        logic [11:0] v_blk;
        logic [9:0]  h_so;
        logic [9:0]  h_sw;
        logic [5:0]  v_so;
        logic [5:0]  v_sw;
        logic        h_pos;
        logic        v_pos;
    } timing_t;

    // Expected signature byte at a position inside the signature.
    function automatic logic [7:0] sig_byte(input logic [2:0] pos);
        return (pos == 3'd0 || pos == 3'd7) ? 8'h00 : 8'hFF;
    endfunction

endpackage

// File: rtl/edid_stream_track.sv
// Tracks the byte position inside a streamed block, checks the signature,
// the length and the modulo-256 sum. Flags are combinational and meant to
// be sampled on the cycle the last byte is accepted.
// Assumes a new block begins with the first valid byte after the last one.
module edid_stream_track
    import edid_pkg::*;
#(
    parameter int BLOCK_LEN = 128,
    parameter int CW        = $clog2(BLOCK_LEN) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic [CW-1:0] idx,
    output logic          blk_start,
    output logic          blk_end,
    output logic          hdr_fail,
    output logic          sum_fail
);

    localparam logic [CW-1:0] LAST_IDX = CW'(BLOCK_LEN - 1);
    localparam logic [CW-1:0] OVER_IDX = CW'(BLOCK_LEN);
    localparam logic [CW-1:0] SIG_END  = CW'(SIG_LEN);

    logic [CW-1:0] cnt;
    logic          hdr_bad_q;
    logic [7:0]    sum_q;
    logic          bad_now;
    logic [7:0]    sum_next;

    assign idx       = cnt;
    assign blk_start = in_valid && (cnt == '0);
    assign blk_end   = in_valid && in_last;

    // Per-byte fault: signature mismatch, or a byte past the block length.
    always_comb begin
        bad_now = 1'b0;
        if (cnt < SIG_END && in_data != sig_byte(cnt[2:0]))
            bad_now = 1'b1;
        if (cnt >= OVER_IDX)
            bad_now = 1'b1;
    end

    assign sum_next = (blk_start ? 8'h00 : sum_q) + in_data;
    assign hdr_fail = (!blk_start && hdr_bad_q) || bad_now || (cnt != LAST_IDX);
    assign sum_fail = (sum_next != 8'h00);

    // Byte position: restarts after last and saturates on overlong blocks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (in_valid) begin
            if (in_last)
                cnt <= '0;
            else if (cnt != '1)
                cnt <= cnt + 1'b1;
        end
    end

    // Sticky signature / overrun fault and running sum within a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_bad_q <= 1'b0;
            sum_q     <= 8'h00;
        end else if (in_valid) begin
            hdr_bad_q <= (!blk_start && hdr_bad_q) || bad_now;
            sum_q     <= sum_next;
        end
    end

    // R10: position only moves on an accepted byte
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt));

endmodule

// File: rtl/edid_dtd_capture.sv
// Collects descriptor bytes from the descriptor region and freezes the
// first descriptor whose leading two bytes are not both zero.
// Assumes the region is contiguous and starts after the signature.
module edid_dtd_capture #(
    parameter int DESC_BASE = 54,
    parameter int DESC_LEN  = 18,
    parameter int DESC_NUM  = 4,
    parameter int CW        = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic [CW-1:0]         idx,
    input  logic                  blk_start,
    output logic [DESC_LEN*8-1:0] dtd_bytes,
    output logic                  found
);

    localparam int              OW      = $clog2(DESC_LEN);
    localparam logic [CW-1:0]   REG_LO  = CW'(DESC_BASE);
    localparam logic [CW-1:0]   REG_HI  = CW'(DESC_BASE + DESC_LEN * DESC_NUM);
    localparam logic [OW-1:0]   OFF_END = OW'(DESC_LEN - 1);

    logic          in_region;
    logic          take;
    logic [OW-1:0] off;

    assign in_region = (idx >= REG_LO) && (idx < REG_HI);
    assign take      = in_valid && in_region && !found;

    // Offset within the current descriptor slot.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_start)
            off <= '0;
        else if (in_valid && in_region)
            off <= (off == OFF_END) ? '0 : off + 1'b1;
    end

    // One byte register per descriptor position.
    for (genvar k = 0; k < DESC_LEN; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                dtd_bytes[k*8 +: 8] <= 8'h00;
            else if (take && off == OW'(k))
                dtd_bytes[k*8 +: 8] <= in_data;
        end
    end

    // Marks the slot in use at its final byte; cleared by a new block.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_start)
            found <= 1'b0;
        else if (take && off == OFF_END && (dtd_bytes[15:0] != 16'h0000))
            found <= 1'b1;
    end

    // R3: once chosen, a descriptor stays selected and its bytes frozen
    p_found_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        found && !blk_start |=> found);
    p_frozen_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        found && !blk_start |=> $stable(dtd_bytes));

endmodule

// File: rtl/edid_dtd_decode.sv
// Combinational unpacking of an 18-byte detailed timing descriptor into
// the timing fields. Assumes DESC_LEN is at least 18.
module edid_dtd_decode
    import edid_pkg::*;
#(
    parameter int DESC_LEN = 18
) (
    input  logic [DESC_LEN*8-1:0] dtd_bytes,
    output timing_t               tim
);

    logic [7:0]  b [DESC_LEN];
    logic [15:0] raw_clk;
    logic        sep_sync;
    logic        unused_bits;

    for (genvar k = 0; k < DESC_LEN; k++) begin : g_split
        assign b[k] = dtd_bytes[k*8 +: 8];
    end

    assign raw_clk  = {b[1], b[0]};
    assign sep_sync = (b[17][4:3] == 2'b11);

    // Assemble the fields split across nibbles and byte 11.
    always_comb begin
        tim.pclk_khz = {1'b0, raw_clk, 3'b000} + {3'b000, raw_clk, 1'b0};
        tim.h_act    = {b[4][7:4], b[2]};
        tim.h_blk    = {b[4][3:0], b[3]};
        tim.v_act    = {b[7][7:4], b[5]};
        tim.v_blk    = {b[7][3:0], b[6]};
        tim.h_so     = {b[11][7:6], b[8]};
        tim.h_sw     = {b[11][5:4], b[9]};
        tim.v_so     = {b[11][3:2], b[10][7:4]};
        tim.v_sw     = {b[11][1:0], b[10][3:0]};
        tim.v_pos    = sep_sync && b[17][2];
        tim.h_pos    = sep_sync && b[17][1];
    end

    assign unused_bits = ^{b[12], b[13], b[14], b[15], b[16], b[17][7:5], b[17][0]};

endmodule

// File: rtl/edid_timing_parser.sv
// Top level: parses a streamed 128-byte base block, reports an error code
// and the decoded preferred timing, held until the next block starts.
// Assumes in_valid/in_last are driven by a byte source with no backpressure.
module edid_timing_parser
    import edid_pkg::*;
#(
    parameter int BLOCK_LEN = 128,
    parameter int DESC_BASE = 54,
    parameter int DESC_LEN  = 18,
    parameter int DESC_NUM  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        done,
    output logic [1:0]  err_code,
    output logic [19:0] pclk_khz,
    output logic [11:0] h_active,
    output logic [11:0] h_blank,
    output logic [11:0] v_active,
    output logic [11:0] v_blank,
    output logic [9:0]  h_sync_off,
    output logic [9:0]  h_sync_wid,
    output logic [5:0]  v_sync_off,
    output logic [5:0]  v_sync_wid,
    output logic        hsync_pos,
    output logic        vsync_pos
);

    localparam int CW = $clog2(BLOCK_LEN) + 1;

    logic [CW-1:0]         idx;
    logic                  blk_start;
    logic                  blk_end;
    logic                  hdr_fail;
    logic                  sum_fail;
    logic [DESC_LEN*8-1:0] dtd_bytes;
    logic                  found;
    timing_t               dec_tim;
    timing_t               res_q;
    edid_err_e             err_now;
    edid_err_e             err_q;

    edid_stream_track #(.BLOCK_LEN(BLOCK_LEN), .CW(CW)) i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .idx       (idx),
        .blk_start (blk_start),
        .blk_end   (blk_end),
        .hdr_fail  (hdr_fail),
        .sum_fail  (sum_fail)
    );

    edid_dtd_capture #(
        .DESC_BASE (DESC_BASE),
        .DESC_LEN  (DESC_LEN),
        .DESC_NUM  (DESC_NUM),
        .CW        (CW)
    ) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .idx       (idx),
        .blk_start (blk_start),
        .dtd_bytes (dtd_bytes),
        .found     (found)
    );

    edid_dtd_decode #(.DESC_LEN(DESC_LEN)) i_decode (
        .dtd_bytes (dtd_bytes),
        .tim       (dec_tim)
    );

    // Error priority: header, then checksum, then missing timing.
    always_comb begin
        if (hdr_fail)
            err_now = ERR_HEADER;
        else if (sum_fail)
            err_now = ERR_CHECKSUM;
        else if (!found)
            err_now = ERR_NO_TIMING;
        else
            err_now = ERR_NONE;
    end

    // Result register: loads on the last byte, clears done on a new block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            err_q <= ERR_NONE;
            res_q <= '0;
        end else if (blk_end) begin
            done  <= 1'b1;
            err_q <= err_now;
            res_q <= (err_now == ERR_NONE) ? dec_tim : '0;
        end else if (blk_start) begin
            done  <= 1'b0;
        end
    end

    assign err_code   = err_q;
    assign pclk_khz   = res_q.pclk_khz;
    assign h_active   = res_q.h_act;
    assign h_blank    = res_q.h_blk;
    assign v_active   = res_q.v_act;
    assign v_blank    = res_q.v_blk;
    assign h_sync_off = res_q.h_so;
    assign h_sync_wid = res_q.h_sw;
    assign v_sync_off = res_q.v_so;
    assign v_sync_wid = res_q.v_sw;
    assign hsync_pos  = res_q.h_pos;
    assign vsync_pos  = res_q.v_pos;

    // R11: done follows the last byte
    p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_last |=> done);
    // R11: results hold while idle
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && !in_valid |=> done && $stable(err_code) && $stable(pclk_khz) && $stable(h_active));
    // R11: a new block clears done
    p_drop_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && in_valid && !in_last |=> !done);
    // R12: errors zero the timing
    p_err_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_code != 2'd0 |-> pclk_khz == 20'd0 && h_active == 12'd0 && v_sync_wid == 6'd0);
    // R5: a selected descriptor always has a nonzero clock
    p_ok_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_code == 2'd0 |-> pclk_khz != 20'd0);

endmodule

// File: tb/test_edid_timing_parser.sv
module test_edid_timing_parser;

    typedef struct packed {
        logic [2:0]  slot;     // 0..3 in-use slot, 4 = none
        logic [1:0]  corrupt;  // 0 none, 1 header, 2 checksum, 3 both
        logic [15:0] pclk;
        logic [11:0] ha;
        logic [11:0] hb;
        logic [11:0] va;
        logic [11:0] vb;
        logic [9:0]  hso;
        logic [9:0]  hsw;
        logic [5:0]  vso;
        logic [5:0]  vsw;
        logic [7:0]  flags;
        logic        gap;
    } row_t;

    localparam int NROWS = 7;
    localparam row_t ROWS [NROWS] = '{
        '{3'd0, 2'd0, 16'h3A98, 12'd1920, 12'd280, 12'd1080, 12'd45, 10'd88,  10'd44,  6'd4,  6'd5,  8'h1E, 1'b0},
        '{3'd2, 2'd0, 16'h1A2B, 12'hABC,  12'h123, 12'h9DE,  12'h345, 10'h3FF, 10'h2AA, 6'h3F, 6'h2A, 8'h18, 1'b1},
        '{3'd3, 2'd0, 16'h0100, 12'd640,  12'd160, 12'd480,  12'd45, 10'd16,  10'd96,  6'd10, 6'd2,  8'h1A, 1'b0},
        '{3'd4, 2'd0, 16'h0000, 12'd0,    12'd0,   12'd0,    12'd0,  10'd0,   10'd0,   6'd0,  6'd0,  8'h00, 1'b0},
        '{3'd1, 2'd1, 16'h2222, 12'd800,  12'd100, 12'd600,  12'd30, 10'd40,  10'd128, 6'd1,  6'd4,  8'h1E, 1'b0},
        '{3'd1, 2'd2, 16'h2222, 12'd800,  12'd100, 12'd600,  12'd30, 10'd40,  10'd128, 6'd1,  6'd4,  8'h1E, 1'b1},
        '{3'd1, 2'd0, 16'h00FF, 12'd1024, 12'd320, 12'd768,  12'd38, 10'd24,  10'd136, 6'd3,  6'd6,  8'h16, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        done;
    logic [1:0]  err_code;
    logic [19:0] pclk_khz;
    logic [11:0] h_active, h_blank, v_active, v_blank;
    logic [9:0]  h_sync_off, h_sync_wid;
    logic [5:0]  v_sync_off, v_sync_wid;
    logic        hsync_pos, vsync_pos;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    bit   expect_drop = 1'b0;
    logic [7:0] blk [0:255];

    always #5 clk = ~clk;

    edid_timing_parser i_edid_timing_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .done(done), .err_code(err_code), .pclk_khz(pclk_khz),
        .h_active(h_active), .h_blank(h_blank), .v_active(v_active), .v_blank(v_blank),
        .h_sync_off(h_sync_off), .h_sync_wid(h_sync_wid),
        .v_sync_off(v_sync_off), .v_sync_wid(v_sync_wid),
        .hsync_pos(hsync_pos), .vsync_pos(vsync_pos)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic enc(input int base, input row_t r);
        blk[base+0]  = r.pclk[7:0];
        blk[base+1]  = r.pclk[15:8];
        blk[base+2]  = r.ha[7:0];
        blk[base+3]  = r.hb[7:0];
        blk[base+4]  = {r.ha[11:8], r.hb[11:8]};
        blk[base+5]  = r.va[7:0];
        blk[base+6]  = r.vb[7:0];
        blk[base+7]  = {r.va[11:8], r.vb[11:8]};
        blk[base+8]  = r.hso[7:0];
        blk[base+9]  = r.hsw[7:0];
        blk[base+10] = {r.vso[3:0], r.vsw[3:0]};
        blk[base+11] = {r.hso[9:8], r.hsw[9:8], r.vso[5:4], r.vsw[5:4]};
        for (int k = 12; k < 17; k++) blk[base+k] = 8'(8'h11 * k);
        blk[base+17] = r.flags;
    endtask

    task automatic build(input row_t r);
        row_t decoy;
        logic [7:0] s;
        decoy = '{3'd0, 2'd0, 16'hBEEF, 12'h111, 12'h222, 12'h333, 12'h444,
                  10'h155, 10'h0AA, 6'h15, 6'h0A, 8'h1C, 1'b0};
        for (int i = 0; i < 256; i++) blk[i] = 8'h00;
        for (int i = 1; i < 7; i++) blk[i] = 8'hFF;
        for (int i = 8; i < 54; i++) blk[i] = 8'(i * 7 + 3);
        for (int sl = 0; sl < 4; sl++) begin
            if (sl < r.slot) begin
                enc(54 + 18 * sl, decoy);
                blk[54 + 18 * sl]     = 8'h00;
                blk[54 + 18 * sl + 1] = 8'h00;
            end else if (sl == int'(r.slot)) begin
                enc(54 + 18 * sl, r);
            end else begin
                enc(54 + 18 * sl, decoy);
            end
        end
        if (r.corrupt[0]) blk[3] = 8'hFE;
        s = 8'h00;
        for (int i = 0; i < 127; i++) s = s + blk[i];
        blk[127] = 8'h00 - s;
        if (r.corrupt[1]) blk[127] = blk[127] + 8'h01;
    endtask

    task automatic send(input int len, input bit gaps);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (expect_drop && i == 1) begin
                chk(done == 1'b0, "R11 done cleared by new block", 32'(done), 32'd0);
                expect_drop = 1'b0;
            end
            if (gaps && (i % 5) == 2) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = blk[i];
            in_last  = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic check_row(input row_t r, input logic [1:0] exp_err);
        bit sep;
        chk(done == 1'b1, "R11 done after last", 32'(done), 32'd1);
        chk(err_code == exp_err, "R1 R2 R4 R9 error code", 32'(err_code), 32'(exp_err));
        if (exp_err != 2'd0) begin
            chk(pclk_khz == 20'd0 && h_active == 12'd0 && v_blank == 12'd0 && h_sync_wid == 10'd0,
                "R12 timing zero on error", 32'(pclk_khz), 32'd0);
        end else begin
            sep = (r.flags[4:3] == 2'b11);
            chk(pclk_khz == 20'(r.pclk) * 20'd10, "R5 pixel clock", 32'(pclk_khz), 32'(r.pclk) * 10);
            chk(h_active == r.ha, "R3 R6 h_active", 32'(h_active), 32'(r.ha));
            chk(h_blank == r.hb, "R6 h_blank", 32'(h_blank), 32'(r.hb));
            chk(v_active == r.va, "R6 v_active", 32'(v_active), 32'(r.va));
            chk(v_blank == r.vb, "R6 v_blank", 32'(v_blank), 32'(r.vb));
            chk(h_sync_off == r.hso, "R7 h_sync_off", 32'(h_sync_off), 32'(r.hso));
            chk(h_sync_wid == r.hsw, "R7 h_sync_wid", 32'(h_sync_wid), 32'(r.hsw));
            chk(v_sync_off == r.vso, "R7 v_sync_off", 32'(v_sync_off), 32'(r.vso));
            chk(v_sync_wid == r.vsw, "R7 v_sync_wid", 32'(v_sync_wid), 32'(r.vsw));
            chk(vsync_pos == (sep & r.flags[2]), "R8 vsync_pos", 32'(vsync_pos), 32'(sep & r.flags[2]));
            chk(hsync_pos == (sep & r.flags[1]), "R8 hsync_pos", 32'(hsync_pos), 32'(sep & r.flags[1]));
        end
    endtask

    function automatic logic [1:0] exp_err_of(input row_t r);
        if (r.corrupt[0]) return 2'd1;
        if (r.corrupt[1]) return 2'd2;
        if (r.slot > 3'd3) return 2'd3;
        return 2'd0;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [1:0]  held_err;
        logic [19:0] held_clk;
        row_t r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(done == 1'b0, "R13 done after reset", 32'(done), 32'd0);
        chk(err_code == 2'd0 && pclk_khz == 20'd0 && h_active == 12'd0,
            "R13 outputs after reset", 32'(pclk_khz), 32'd0);

        // Table of vectors
        for (int n = 0; n < NROWS; n++) begin
            build(ROWS[n]);
            send(128, ROWS[n].gap);
            check_row(ROWS[n], exp_err_of(ROWS[n]));
        end

        // R11 hold while idle
        held_err = err_code;
        held_clk = pclk_khz;
        repeat (5) @(negedge clk);
        chk(done == 1'b1 && err_code == held_err && pclk_khz == held_clk,
            "R11 results held while idle", 32'(pclk_khz), 32'(held_clk));

        // R11 drop on next block, then a good block again
        r = ROWS[0];
        build(r);
        expect_drop = 1'b1;
        send(128, 1'b0);
        check_row(r, 2'd0);

        // R10 short block
        build(ROWS[0]);
        send(100, 1'b0);
        chk(err_code == 2'd1, "R10 short block", 32'(err_code), 32'd1);

        // R10 overlong block (extra zero bytes keep the sum)
        build(ROWS[0]);
        send(130, 1'b0);
        chk(err_code == 2'd1, "R10 overlong block", 32'(err_code), 32'd1);

        // R9 header and checksum both bad
        r = ROWS[4];
        r.corrupt = 2'd3;
        build(r);
        send(128, 1'b0);
        chk(err_code == 2'd1, "R9 header over checksum", 32'(err_code), 32'd1);

        // R9 checksum bad and no timing
        r = ROWS[3];
        r.corrupt = 2'd2;
        build(r);
        send(128, 1'b0);
        chk(err_code == 2'd2, "R9 checksum over no timing", 32'(err_code), 32'd2);
        chk(pclk_khz == 20'd0, "R12 zero after checksum error", 32'(pclk_khz), 32'd0);

        // Recovery with a good block
        build(ROWS[1]);
        send(128, 1'b0);
        check_row(ROWS[1], 2'd0);

        finish_run();
    end

endmodule